// File: doc/BRIEF.md
# Debug Communications Mailbox

This block moves 32-bit words in both directions between a processor core and an external debugger. Each direction has a one-word mailbox and a full flag. The processor reaches the block through register-transfer accesses that carry a small register number. Register 0 holds a read-only status word. Register 1 is the data port: a write goes to the outbound mailbox and a read comes from the inbound mailbox.

The debugger reaches the block through a serial scan path with three strobes. A capture strobe takes a snapshot of the outbound word and both flags into a 34-bit shift register. Shift strobes move that snapshot out serially while new bits come in. An update strobe acts on the shifted-in bits. If a write-enable bit is set, the update deposits the shifted-in word into the inbound mailbox. The update also releases the outbound mailbox if the last capture found it full.

A transfer that would overwrite an occupied mailbox is dropped and raises a one-cycle overrun pulse on that side. When a mailbox is emptied and refilled in the same cycle, the emptying is applied first, so the new word is kept.

Top module: `dbgMailbox`

## Requirements
- R1: After reset both mailboxes are empty (W=0, R=0), a status read returns 0x1000_0000, and both overrun outputs are low.
- R2: A processor read of register 0 returns the status word: bits [31:28] = 4'b0001, bit 1 = W (outbound occupied), bit 0 = R (inbound unread), and bits [27:2] zero.
- R3: A processor write to register 1 while W=0 loads the outbound word and sets W, visible from the following cycle.
- R4: A processor write to register 1 while W=1 leaves the outbound word unchanged. `cpuOverrun` goes high in the following cycle.
- R5: A processor read of register 1 returns the inbound word. R reads 0 from the following cycle.
- R6: A capture loads the scan register with R at bit 0, W at bit 1 and the outbound word at bits [33:2]. Each shift presents bit 0 on `dbgTdo`, moves the register one place toward bit 0, and enters `dbgTdi` at bit 33.
- R7: An update with scan bit 0 = 1 while R=0 writes scan bits [33:2] into the inbound word and sets R. An update with scan bit 0 = 0 deposits nothing.
- R8: An update with scan bit 0 = 1 while R=1 leaves the inbound word unchanged, and `dbgOverrun` goes high in the following cycle.
- R9: An update clears W only when the most recent capture saw W=1. An update with no capture since the last update leaves W unchanged.
- R10: A processor write to register 0, or any access to a register number other than 0 and 1, changes no state. Such an access returns zero.
- R11: When a clear and a set of the same flag land in the same cycle, the new transfer is accepted with no overrun and the flag stays set. The clear is either a scan completion with a processor write, or a processor read with a deposit.
- R12: Each overrun pulse lasts one cycle and falls if no further offending access follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuSel | input | 1 | Processor access strobe |
| cpuWr | input | 1 | 1 = write, 0 = read |
| cpuRegNum | input | 4 | Register number |
| cpuWrData | input | 32 | Processor write data |
| cpuRdData | output | 32 | Processor read data (combinational) |
| cpuOverrun | output | 1 | Dropped processor write pulse |
| dbgCapture | input | 1 | Scan capture strobe |
| dbgShift | input | 1 | Scan shift strobe |
| dbgUpdate | input | 1 | Scan update strobe |
| dbgTdi | input | 1 | Scan serial in |
| dbgTdo | output | 1 | Scan serial out |
| dbgOverrun | output | 1 | Dropped debugger deposit pulse |

## Verification
The bench targets the cycles where one side empties a mailbox just as the other side refills it. A design that applied the set before the clear would lose the new word, or would flag a false overrun. It also targets writes into an occupied outbound mailbox and deposits onto an unread inbound word. A design that overwrote the data instead of dropping it would shift out or return the wrong word. An update that is not preceded by a capture is checked separately, because a design that cleared W on any update would discard a word the debugger never saw. Reads of unused register numbers and writes to the status register are checked for zero data and for no change in the flags.

// File: rtl/dbgMailboxPkg.sv
package dbgMailboxPkg;
  localparam int unsigned STATUS_REG = 0;
  localparam int unsigned DATA_REG   = 1;

  // strobes from the control half to the datapath half
  typedef struct packed {
    logic loadOut;   // accept processor word into outbound mailbox
    logic loadIn;    // accept scanned word into inbound mailbox
    logic capture;   // snapshot flags and outbound word into scan register
    logic shift;     // move scan register one place
  } dpCtrlT;
endpackage

// File: rtl/dbgMailboxCtrl.sv
module dbgMailboxCtrl
  import dbgMailboxPkg::*;
#(
  parameter int unsigned REG_NUM_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cpuSel,
  input  logic                 cpuWr,
  input  logic [REG_NUM_W-1:0] cpuRegNum,
  input  logic                 dbgCapture,
  input  logic                 dbgShift,
  input  logic                 dbgUpdate,
  input  logic                 scanWrEn,
  output logic                 wFull,
  output logic                 rFull,
  output logic                 cpuOverrun,
  output logic                 dbgOverrun,
  output dpCtrlT               ctrl
);
  localparam logic [REG_NUM_W-1:0] DATA_SEL = REG_NUM_W'(DATA_REG);

  logic cpuWrData1, cpuRdData1, depositReq, scanDone;
  logic wHeld, rHeld, acceptOut, acceptIn;
  logic capturedW;

  assign cpuWrData1 = cpuSel &  cpuWr & (cpuRegNum == DATA_SEL);
  assign cpuRdData1 = cpuSel & ~cpuWr & (cpuRegNum == DATA_SEL);
  assign depositReq = dbgUpdate & scanWrEn;
  assign scanDone   = dbgUpdate & capturedW;

  // clear first, then set
  assign wHeld     = wFull & ~scanDone;
  assign rHeld     = rFull & ~cpuRdData1;
  assign acceptOut = cpuWrData1 & ~wHeld;
  assign acceptIn  = depositReq & ~rHeld;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wFull      <= 1'b0;
      rFull      <= 1'b0;
      cpuOverrun <= 1'b0;
      dbgOverrun <= 1'b0;
      capturedW  <= 1'b0;
    end else begin
      wFull      <= wHeld | acceptOut;
      rFull      <= rHeld | acceptIn;
      cpuOverrun <= cpuWrData1 & wHeld;
      dbgOverrun <= depositReq & rHeld;
      if (dbgCapture)     capturedW <= wFull;
      else if (dbgUpdate) capturedW <= 1'b0;
    end
  end

  always_comb begin
    ctrl         = '0;
    ctrl.loadOut = acceptOut;
    ctrl.loadIn  = acceptIn;
    ctrl.capture = dbgCapture;
    ctrl.shift   = dbgShift & ~dbgCapture;
  end

  // R1
  reset_empty_chk: assert property (@(posedge clk)
    !rstN |=> (!wFull && !rFull && !cpuOverrun && !dbgOverrun));

  // R3
  w_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWrData1 && !wFull) |=> wFull);

  // R4
  cpu_ovr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWrData1 && wFull && !scanDone) |=> (cpuOverrun && wFull));

  // R5
  r_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRdData1 && !depositReq) |=> !rFull);

  // R8
  dbg_ovr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (depositReq && rFull && !cpuRdData1) |=> (dbgOverrun && rFull));

  // R9
  w_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wFull && !capturedW && !dbgCapture) |=> wFull);

  // R11
  refill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (depositReq && cpuRdData1) |=> (rFull && !dbgOverrun));
endmodule

// File: rtl/dbgMailboxDatapath.sv
module dbgMailboxDatapath
  import dbgMailboxPkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned REG_NUM_W = 4,
  parameter int unsigned VER_W     = 4,
  parameter logic [VER_W-1:0] VERSION = 4'b0001
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpCtrlT               ctrl,
  input  logic                 wFull,
  input  logic                 rFull,
  input  logic                 cpuSel,
  input  logic                 cpuWr,
  input  logic [REG_NUM_W-1:0] cpuRegNum,
  input  logic [DATA_W-1:0]    cpuWrData,
  input  logic                 dbgTdi,
  output logic [DATA_W-1:0]    cpuRdData,
  output logic                 dbgTdo,
  output logic                 scanWrEn
);
  localparam int unsigned SCAN_W = DATA_W + 2;
  localparam int unsigned PAD_W  = DATA_W - VER_W - 2;
  localparam logic [REG_NUM_W-1:0] STATUS_SEL = REG_NUM_W'(STATUS_REG);
  localparam logic [REG_NUM_W-1:0] DATA_SEL   = REG_NUM_W'(DATA_REG);

  logic [DATA_W-1:0] outWord, inWord, statusWord;
  logic [SCAN_W-1:0] scanReg;

  assign statusWord = {VERSION, {PAD_W{1'b0}}, wFull, rFull};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outWord <= '0;
      inWord  <= '0;
      scanReg <= '0;
    end else begin
      if (ctrl.loadOut) outWord <= cpuWrData;
      if (ctrl.loadIn)  inWord  <= scanReg[SCAN_W-1:2];
      if (ctrl.capture)    scanReg <= {outWord, wFull, rFull};
      else if (ctrl.shift) scanReg <= {dbgTdi, scanReg[SCAN_W-1:1]};
    end
  end

  always_comb begin
    cpuRdData = '0;
    if (cpuSel && !cpuWr) begin
      if (cpuRegNum == STATUS_SEL)    cpuRdData = statusWord;
      else if (cpuRegNum == DATA_SEL) cpuRdData = inWord;
    end
  end

  assign dbgTdo   = scanReg[0];
  assign scanWrEn = scanReg[0];

  // R6
  capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.capture |=> (scanReg[1:0] == {$past(wFull), $past(rFull)}));

  // R7
  deposit_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.loadIn |=> (inWord == $past(scanReg[SCAN_W-1:2])));

  // R10
  unused_reg_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuSel && !cpuWr && cpuRegNum != STATUS_SEL && cpuRegNum != DATA_SEL)
      |-> (cpuRdData == '0));

  // R2
  version_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuSel && !cpuWr && cpuRegNum == STATUS_SEL)
      |-> (cpuRdData[DATA_W-1 -: VER_W] == VERSION && cpuRdData[DATA_W-VER_W-1:2] == '0));
endmodule

// File: rtl/dbgMailbox.sv
module dbgMailbox
  import dbgMailboxPkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned REG_NUM_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cpuSel,
  input  logic                 cpuWr,
  input  logic [REG_NUM_W-1:0] cpuRegNum,
  input  logic [DATA_W-1:0]    cpuWrData,
  output logic [DATA_W-1:0]    cpuRdData,
  output logic                 cpuOverrun,
  input  logic                 dbgCapture,
  input  logic                 dbgShift,
  input  logic                 dbgUpdate,
  input  logic                 dbgTdi,
  output logic                 dbgTdo,
  output logic                 dbgOverrun
);
  dpCtrlT ctrl;
  logic   wFull, rFull, scanWrEn;

  dbgMailboxCtrl #(.REG_NUM_W(REG_NUM_W)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .cpuSel(cpuSel), .cpuWr(cpuWr), .cpuRegNum(cpuRegNum),
    .dbgCapture(dbgCapture), .dbgShift(dbgShift), .dbgUpdate(dbgUpdate),
    .scanWrEn(scanWrEn),
    .wFull(wFull), .rFull(rFull),
    .cpuOverrun(cpuOverrun), .dbgOverrun(dbgOverrun),
    .ctrl(ctrl)
  );

  dbgMailboxDatapath #(.DATA_W(DATA_W), .REG_NUM_W(REG_NUM_W)) i_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .wFull(wFull), .rFull(rFull),
    .cpuSel(cpuSel), .cpuWr(cpuWr), .cpuRegNum(cpuRegNum), .cpuWrData(cpuWrData),
    .dbgTdi(dbgTdi),
    .cpuRdData(cpuRdData), .dbgTdo(dbgTdo), .scanWrEn(scanWrEn)
  );
endmodule

// File: tb/test_dbgMailbox.sv
`timescale 1ns/1ps
module test_dbgMailbox;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuSel = 1'b0, cpuWr = 1'b0;
  logic [3:0]  cpuRegNum = '0;
  logic [31:0] cpuWrData = '0;
  logic [31:0] cpuRdData;
  logic        cpuOverrun, dbgOverrun;
  logic        dbgCapture = 1'b0, dbgShift = 1'b0, dbgUpdate = 1'b0, dbgTdi = 1'b0;
  logic        dbgTdo;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dbgMailbox i_dbgMailbox (
    .clk(clk), .rstN(rstN),
    .cpuSel(cpuSel), .cpuWr(cpuWr), .cpuRegNum(cpuRegNum), .cpuWrData(cpuWrData),
    .cpuRdData(cpuRdData), .cpuOverrun(cpuOverrun),
    .dbgCapture(dbgCapture), .dbgShift(dbgShift), .dbgUpdate(dbgUpdate),
    .dbgTdi(dbgTdi), .dbgTdo(dbgTdo), .dbgOverrun(dbgOverrun)
  );

  typedef struct packed {
    logic        wr;
    logic [3:0]  rn;
    logic [31:0] wdata;
    logic [31:0] expRd;
    logic        expOvr;
    logic [3:0]  req;
  } vecT;

  localparam vecT VECS [10] = '{
    '{1'b0, 4'd0, 32'h0,          32'h1000_0000, 1'b0, 4'd2 },  // R2 status after reset
    '{1'b1, 4'd1, 32'hA5A5_0001,  32'h0,         1'b0, 4'd3 },  // R3 first write accepted
    '{1'b0, 4'd0, 32'h0,          32'h1000_0002, 1'b0, 4'd3 },  // R3 W now set
    '{1'b1, 4'd1, 32'hBEEF_0002,  32'h0,         1'b1, 4'd4 },  // R4 write while full
    '{1'b0, 4'd5, 32'h0,          32'h0,         1'b0, 4'd12},  // R12 pulse gone; R10 zero
    '{1'b1, 4'd0, 32'hFFFF_FFFF,  32'h0,         1'b0, 4'd10},  // R10 status write
    '{1'b1, 4'd7, 32'h1234_5678,  32'h0,         1'b0, 4'd10},  // R10 other reg write
    '{1'b0, 4'd0, 32'h0,          32'h1000_0002, 1'b0, 4'd10},  // R10 flags unchanged
    '{1'b0, 4'd1, 32'h0,          32'h0,         1'b0, 4'd5 },  // R5 empty inbound reads 0
    '{1'b0, 4'd0, 32'h0,          32'h1000_0002, 1'b0, 4'd5 }   // R5 R still 0
  };

  task automatic check(input int req, input logic [33:0] act, input logic [33:0] exp,
                       input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cpuOp(input logic wr, input logic [3:0] rn, input logic [31:0] d,
                       output logic [31:0] rd);
    cpuSel = 1'b1; cpuWr = wr; cpuRegNum = rn; cpuWrData = d;
    #1 rd = cpuRdData;
    @(posedge clk); @(negedge clk);
    cpuSel = 1'b0; cpuWr = 1'b0; cpuRegNum = '0; cpuWrData = '0;
  endtask

  task automatic doCapture();
    dbgCapture = 1'b1;
    @(posedge clk); @(negedge clk);
    dbgCapture = 1'b0;
  endtask

  task automatic doShift(input logic [33:0] din, output logic [33:0] dout);
    for (int i = 0; i < 34; i++) begin
      dbgTdi = din[i]; dbgShift = 1'b1;
      #1 dout[i] = dbgTdo;
      @(posedge clk); @(negedge clk);
    end
    dbgShift = 1'b0; dbgTdi = 1'b0;
  endtask

  task automatic doUpdate();
    dbgUpdate = 1'b1;
    @(posedge clk); @(negedge clk);
    dbgUpdate = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [33:0] so;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(1, {33'b0, cpuOverrun}, 34'h0, "cpuOverrun after reset");
    check(1, {33'b0, dbgOverrun}, 34'h0, "dbgOverrun after reset");
    cpuOp(1'b0, 4'd0, 32'h0, rd);
    check(1, {2'b0, rd}, {2'b0, 32'h1000_0000}, "status after reset");

    // processor-side vector table
    foreach (VECS[k]) begin
      cpuOp(VECS[k].wr, VECS[k].rn, VECS[k].wdata, rd);
      check(int'(VECS[k].req), {2'b0, rd}, {2'b0, VECS[k].expRd}, $sformatf("vector %0d read", k));
      check(int'(VECS[k].req), {33'b0, cpuOverrun}, {33'b0, VECS[k].expOvr},
            $sformatf("vector %0d overrun", k));
    end

    // R6 / R4: capture shows first word and flags; R7 deposit; R9 release
    doCapture();
    doShift({32'hC0DE_0003, 1'b0, 1'b1}, so);
    check(6, so, {32'hA5A5_0001, 1'b1, 1'b0}, "captured scan image (R4 word kept)");
    doUpdate();
    cpuOp(1'b0, 4'd0, 32'h0, rd);
    check(9, {2'b0, rd}, {2'b0, 32'h1000_0001}, "status after scan-out and deposit (R7)");
    cpuOp(1'b0, 4'd1, 32'h0, rd);
    check(5, {2'b0, rd}, {2'b0, 32'hC0DE_0003}, "inbound word read");
    cpuOp(1'b0, 4'd0, 32'h0, rd);
    check(5, {2'b0, rd}, {2'b0, 32'h1000_0000}, "R cleared by read");

    // R8: deposit onto unread word
    doShift({32'hD00D_0004, 1'b0, 1'b1}, so);
    doUpdate();
    doShift({32'hE000_0005, 1'b0, 1'b1}, so);
    doUpdate();
    check(8, {33'b0, dbgOverrun}, 34'h1, "dbgOverrun on full deposit");
    @(negedge clk);
    check(12, {33'b0, dbgOverrun}, 34'h0, "dbgOverrun one cycle");
    cpuOp(1'b0, 4'd1, 32'h0, rd);
    check(8, {2'b0, rd}, {2'b0, 32'hD00D_0004}, "first inbound word kept");

    // R7: update without write-enable deposits nothing
    doShift({32'hF00F_0006, 1'b0, 1'b0}, so);
    doUpdate();
    cpuOp(1'b0, 4'd0, 32'h0, rd);
    check(7, {2'b0, rd}, {2'b0, 32'h1000_0000}, "no deposit when enable low");

    // R9: update with no capture keeps W
    cpuOp(1'b1, 4'd1, 32'h1111_0007, rd);
    doUpdate();
    cpuOp(1'b0, 4'd0, 32'h0, rd);
    check(9, {2'b0, rd}, {2'b0, 32'h1000_0002}, "W kept without capture");
    doCapture();
    doShift(34'h0, so);
    check(6, so, {32'h1111_0007, 1'b1, 1'b0}, "captured word F");
    doUpdate();
    cpuOp(1'b0, 4'd0, 32'h0, rd);
    check(9, {2'b0, rd}, {2'b0, 32'h1000_0000}, "W cleared after capture+update");

    // R11: read and deposit same cycle
    doShift({32'h6666_0008, 1'b0, 1'b1}, so);
    doUpdate();
    doShift({32'h7777_0009, 1'b0, 1'b1}, so);
    cpuSel = 1'b1; cpuWr = 1'b0; cpuRegNum = 4'd1; dbgUpdate = 1'b1;
    #1 rd = cpuRdData;
    @(posedge clk); @(negedge clk);
    cpuSel = 1'b0; cpuRegNum = '0; dbgUpdate = 1'b0;
    check(11, {2'b0, rd}, {2'b0, 32'h6666_0008}, "read during deposit");
    check(11, {33'b0, dbgOverrun}, 34'h0, "no dbgOverrun on refill");
    cpuOp(1'b0, 4'd1, 32'h0, rd);
    check(11, {2'b0, rd}, {2'b0, 32'h7777_0009}, "refilled inbound word");

    // R11: scan completion and processor write same cycle
    cpuOp(1'b1, 4'd1, 32'h8888_000A, rd);
    doCapture();
    doShift(34'h0, so);
    cpuSel = 1'b1; cpuWr = 1'b1; cpuRegNum = 4'd1; cpuWrData = 32'h9999_000B; dbgUpdate = 1'b1;
    @(posedge clk); @(negedge clk);
    cpuSel = 1'b0; cpuWr = 1'b0; cpuRegNum = '0; cpuWrData = '0; dbgUpdate = 1'b0;
    check(11, {33'b0, cpuOverrun}, 34'h0, "no cpuOverrun on refill");
    doCapture();
    doShift(34'h0, so);
    check(11, so, {32'h9999_000B, 1'b1, 1'b0}, "refilled outbound word");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule